// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns single register writes into NAND flash bus activity. Software loads a command byte or an address byte into a holding register. It then sets one bit in a trigger register, and the engine performs one operation on the flash pins. The six operations are:

- a command latch cycle
- an address latch cycle
- a page program that streams bytes out of a local buffer RAM
- a page read that fills that buffer
- an identification read
- a status read

Each operation is one step started by software. When it ends, a sticky completion flag is set and a maskable interrupt can be raised. The flash ready/busy line is watched inside the engine, so software never polls it.

A page transfer moves the configured main-area size plus the spare area. The spare area is programmed in 16-bit units. Strobe low and high widths are fixed by parameters. A soft reset in the configuration register aborts any operation and returns the engine to idle. The buffer RAM sits outside the block. It is reached through a single-port interface whose read data arrives one clock after the address.

Top module: `nand_op_engine`

## Requirements
- R1: Setting trigger bit 0 (register 2) produces exactly one write-strobe pulse with the command-latch pin high, the address-latch pin low, and I/O equal to the low byte of register 0.
- R2: Setting trigger bit 1 produces exactly one write-strobe pulse with the address-latch pin high, the command-latch pin low, and I/O equal to the low byte of register 1.
- R3: Trigger-register bit 15 reads 0 after reset. It becomes 1 when an operation completes and stays 1 across trigger writes that carry bit 15 = 1. A trigger write with bit 15 = 0 clears it.
- R4: The irq output is 1 exactly when the done flag is 1 and configuration (register 3) bit 4 is 0. It follows either change one clock later, and unmasking while done is already set raises it.
- R5: While an operation is in progress, trigger bits 5:0 read back as the one-hot code of that operation. A further trigger write starts nothing.
- R6: When several trigger bits are set in one write, only the lowest-numbered one is performed.
- R7: A page read (trigger bit 3) issues no read-strobe pulse while the ready/busy input is low. Once that input is high, it captures page-size plus twice register 5 bytes into buffer offsets 0 upward, under the buffer number in register 4 bits 2:0.
- R8: A page program (trigger bit 2) sends the same byte count from buffer offsets 0 upward, one write-strobe pulse per byte, with both latch pins low.
- R9: An ID read (trigger bit 4) captures exactly ID_BYTES bytes into buffer 0, offsets 0 upward, whatever buffer number register 4 holds.
- R10: A status read (trigger bit 5) captures exactly one byte into buffer 0, offset 0.
- R11: Writing configuration bit 6 = 1 starts a soft reset. That bit reads 1 while the reset runs and 0 afterwards. The reset aborts the current operation and clears the done flag.
- R12: Chip-enable output n is low only when configuration bit 7 is 1 and register 4 bits 6:5 equal n. All other chip-enable outputs stay high.
- R13: Output pages_per_block equals 32 shifted left by configuration bits 10:9, giving 32, 64, 128 or 256.
- R14: Each write-strobe low pulse lasts WE_LO clocks and each read-strobe low pulse lasts RE_LO clocks. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 command, 1 address, 2 trigger, 3 config, 4 buffer/chip select, 5 spare size) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| pages_per_block | output | 9 | Decoded erase-block size in pages |
| buf_addr | output | OFS_W+3 | Buffer RAM address {buffer number, byte offset} |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data, one clock after address |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | NCS | Active-low chip enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Flash I/O bus output value |
| nand_io_oe | output | 1 | Flash I/O bus output enable |
| nand_io_in | input | 8 | Flash I/O bus input value |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The hardest state to reach from the ports is a page read parked behind a low ready/busy line. While it waits, two things must be shown: a second trigger is refused, and a soft reset can abort the parked read.

The bench holds the ready/busy input low before triggering a page read. While the read waits, it writes a conflicting trigger and reads back the trigger register, and it counts read-strobe edges to confirm none occurred. It then releases the line and checks the captured buffer image. In a later pass it leaves the line low and issues a soft reset instead.

Command and address bytes, spare sizes and buffer contents are drawn from a seeded random stream.

// File: rtl/nand_eng_pkg.sv
`timescale 1ns/1ps
package nand_eng_pkg;
  // register indices
  localparam logic [2:0] RA_CMD   = 3'd0;
  localparam logic [2:0] RA_ADR   = 3'd1;
  localparam logic [2:0] RA_TRIG  = 3'd2;
  localparam logic [2:0] RA_CFG   = 3'd3;
  localparam logic [2:0] RA_BUF   = 3'd4;
  localparam logic [2:0] RA_SPARE = 3'd5;
  // configuration bit positions
  localparam int CB_MASK = 4;
  localparam int CB_SRST = 6;
  localparam int CB_CE   = 7;
  localparam int TB_DONE = 15;

  typedef enum logic [2:0] {
    OP_NONE, OP_CMD, OP_ADR, OP_PROG, OP_READ, OP_ID, OP_STAT
  } op_e;
endpackage

// File: rtl/nand_eng_regs.sv
`timescale 1ns/1ps
module nand_eng_regs import nand_eng_pkg::*; #(
  parameter int SPARE_W = 7,
  parameter int NCS     = 4,
  parameter int RST_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               fin,
  output logic               go,
  output op_e                op,
  output logic [7:0]         cmd_byte,
  output logic [7:0]         adr_byte,
  output logic [2:0]         rba,
  output logic [SPARE_W-1:0] spare_words,
  output logic               srst_on,
  output logic               irq,
  output logic [NCS-1:0]     ce_n,
  output logic [8:0]         ppb
);
  localparam int RCW = $clog2(RST_CYC + 1);

  logic [15:0] cmd_r, adr_r, cfg_r, bufsel_r;
  logic [5:0]  op_q, pri;
  logic        done_q, wr_trig, accept;
  logic [RCW-1:0] srst_cnt;

  assign srst_on = (srst_cnt != '0);
  assign wr_trig = reg_we && (reg_addr == RA_TRIG);
  assign pri     = reg_wdata[5:0] & (~reg_wdata[5:0] + 6'd1);
  assign accept  = wr_trig && (op_q == '0) && !srst_on && (reg_wdata[5:0] != '0);
  assign cmd_byte = cmd_r[7:0];
  assign adr_byte = adr_r[7:0];
  assign rba      = bufsel_r[2:0];

  always_comb begin
    unique case (op_q)
      6'b000001: op = OP_CMD;
      6'b000010: op = OP_ADR;
      6'b000100: op = OP_PROG;
      6'b001000: op = OP_READ;
      6'b010000: op = OP_ID;
      6'b100000: op = OP_STAT;
      default:   op = OP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_r <= '0; adr_r <= '0; cfg_r <= '0; bufsel_r <= '0;
      spare_words <= '0; op_q <= '0; done_q <= 1'b0; go <= 1'b0;
      srst_cnt <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_CMD:   cmd_r <= reg_wdata;
          RA_ADR:   adr_r <= reg_wdata;
          RA_CFG:   cfg_r <= reg_wdata;
          RA_BUF:   bufsel_r <= reg_wdata;
          RA_SPARE: spare_words <= reg_wdata[SPARE_W-1:0];
          default: ;
        endcase
      end
      if (reg_we && reg_addr == RA_CFG && reg_wdata[CB_SRST])
        srst_cnt <= RCW'(RST_CYC);
      else if (srst_on)
        srst_cnt <= srst_cnt - RCW'(1);
      go <= accept;
      if (srst_on) begin
        op_q <= '0; done_q <= 1'b0; go <= 1'b0;
      end else begin
        if (fin) op_q <= '0;
        else if (accept) op_q <= pri;
        if (fin) done_q <= 1'b1;
        else if (wr_trig && !reg_wdata[TB_DONE]) done_q <= 1'b0;
      end
    end
  end

  // registered side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0; ppb <= 9'd32; reg_rdata <= '0;
    end else begin
      irq <= done_q && !cfg_r[CB_MASK];
      ppb <= 9'd32 << cfg_r[10:9];
      case (reg_addr)
        RA_CMD:   reg_rdata <= cmd_r;
        RA_ADR:   reg_rdata <= adr_r;
        RA_TRIG:  reg_rdata <= {done_q, 9'b0, op_q};
        RA_CFG:   reg_rdata <= {cfg_r[15:7], srst_on, cfg_r[5:0]};
        RA_BUF:   reg_rdata <= bufsel_r;
        RA_SPARE: reg_rdata <= 16'(spare_words);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) ce_n[i] <= 1'b1;
      else     ce_n[i] <= !(cfg_r[CB_CE] && (bufsel_r[6:5] == 2'(i)));
    end
  end

  p_onehot_op_r6: assert property (@(posedge clk) disable iff (rst) $onehot0(op_q));
  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    (op_q != '0 && wr_trig && !fin && !srst_on) |=> $stable(op_q));
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(wr_trig && !reg_wdata[TB_DONE]) && !srst_on) |=> done_q);
  p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && !cfg_r[CB_MASK]) |=> irq);
  p_irq_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (!done_q || cfg_r[CB_MASK]) |=> !irq);
  p_srst_idle_r11: assert property (@(posedge clk) disable iff (rst)
    srst_on |=> (op_q == '0 && !done_q));
endmodule

// File: rtl/nand_eng_seq.sv
`timescale 1ns/1ps
module nand_eng_seq import nand_eng_pkg::*; #(
  parameter int PAGE_BYTES = 512,
  parameter int SPARE_W    = 7,
  parameter int OFS_W      = 10,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 2,
  parameter int RE_HI      = 2,
  parameter int ID_BYTES   = 5
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               go,
  input  op_e                op,
  input  logic [7:0]         cmd_byte,
  input  logic [7:0]         adr_byte,
  input  logic [2:0]         rba,
  input  logic [SPARE_W-1:0] spare_words,
  output logic               fin,
  output logic [OFS_W+2:0]   buf_addr,
  output logic               buf_we,
  output logic [7:0]         buf_wdata,
  input  logic [7:0]         buf_rdata,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic [7:0]         io_out,
  output logic               io_oe,
  input  logic [7:0]         io_in,
  input  logic               rb_n
);
  localparam int T1   = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int T2   = (RE_LO > RE_HI) ? RE_LO : RE_HI;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT_RB, S_FETCH, S_LOAD, S_WLO, S_WHI, S_RLO, S_RHI} st_e;
  st_e st;
  op_e cur;
  logic [TW-1:0]    tmr;
  logic [OFS_W-1:0] cnt, tot_m1, page_m1;
  logic [2:0]       bank;
  logic             rb_s1, rb_ok;

  assign page_m1 = OFS_W'(PAGE_BYTES) + OFS_W'({spare_words, 1'b0}) - OFS_W'(1);

  always_ff @(posedge clk) begin
    if (clr) begin rb_s1 <= 1'b0; rb_ok <= 1'b0; end
    else     begin rb_s1 <= rb_n; rb_ok <= rb_s1; end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st <= S_IDLE; cur <= OP_NONE; tmr <= '0; cnt <= '0; tot_m1 <= '0; bank <= '0;
      fin <= 1'b0; buf_addr <= '0; buf_we <= 1'b0; buf_wdata <= '0;
      cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1; re_n <= 1'b1; io_out <= '0; io_oe <= 1'b0;
    end else begin
      fin <= 1'b0;
      buf_we <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          cur  <= op;
          cnt  <= '0;
          bank <= (op == OP_ID || op == OP_STAT) ? 3'd0 : rba;
          tot_m1 <= (op == OP_ID) ? OFS_W'(ID_BYTES - 1) :
                    (op == OP_STAT) ? '0 : page_m1;
          case (op)
            OP_CMD, OP_ADR: begin
              io_out <= (op == OP_CMD) ? cmd_byte : adr_byte;
              cle <= (op == OP_CMD); ale <= (op == OP_ADR);
              io_oe <= 1'b1; we_n <= 1'b0; tmr <= TW'(WE_LO - 1); st <= S_WLO;
            end
            OP_PROG, OP_READ: st <= S_WAIT_RB;
            OP_ID, OP_STAT: begin re_n <= 1'b0; tmr <= TW'(RE_LO - 1); st <= S_RLO; end
            default: ;
          endcase
        end
        S_WAIT_RB: if (rb_ok) begin
          if (cur == OP_PROG) begin buf_addr <= {bank, cnt}; st <= S_FETCH; end
          else begin re_n <= 1'b0; tmr <= TW'(RE_LO - 1); st <= S_RLO; end
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          io_out <= buf_rdata; io_oe <= 1'b1; we_n <= 1'b0;
          tmr <= TW'(WE_LO - 1); st <= S_WLO;
        end
        S_WLO: if (tmr == '0) begin we_n <= 1'b1; tmr <= TW'(WE_HI - 1); st <= S_WHI; end
               else tmr <= tmr - TW'(1);
        S_WHI: if (tmr != '0) tmr <= tmr - TW'(1);
          else if (cur == OP_PROG && cnt != tot_m1) begin
            cnt <= cnt + OFS_W'(1); buf_addr <= {bank, cnt + OFS_W'(1)}; st <= S_FETCH;
          end else begin
            cle <= 1'b0; ale <= 1'b0; io_oe <= 1'b0; fin <= 1'b1; st <= S_IDLE;
          end
        S_RLO: if (tmr == '0) begin
          buf_we <= 1'b1; buf_wdata <= io_in; buf_addr <= {bank, cnt};
          re_n <= 1'b1; tmr <= TW'(RE_HI - 1); st <= S_RHI;
        end else tmr <= tmr - TW'(1);
        S_RHI: if (tmr != '0) tmr <= tmr - TW'(1);
          else if (cnt != tot_m1) begin
            cnt <= cnt + OFS_W'(1); re_n <= 1'b0; tmr <= TW'(RE_LO - 1); st <= S_RLO;
          end else begin fin <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_excl_r14: assert property (@(posedge clk) disable iff (clr) !(!we_n && !re_n));
  p_we_hold_r14: assert property (@(posedge clk) disable iff (clr)
    (st == S_WLO && tmr != '0) |=> !we_n);
  p_re_hold_r14: assert property (@(posedge clk) disable iff (clr)
    (st == S_RLO && tmr != '0) |=> !re_n);
  p_wait_rb_r7: assert property (@(posedge clk) disable iff (clr)
    (st == S_WAIT_RB && !rb_ok) |=> (re_n && we_n));
endmodule

// File: rtl/nand_op_engine.sv
`timescale 1ns/1ps
module nand_op_engine import nand_eng_pkg::*; #(
  parameter int PAGE_BYTES = 512,
  parameter int SPARE_W    = 7,
  parameter int NCS        = 4,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 2,
  parameter int RE_HI      = 2,
  parameter int ID_BYTES   = 5,
  parameter int RST_CYC    = 4,
  localparam int OFS_W = $clog2(PAGE_BYTES + 2 * ((1 << SPARE_W) - 1))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             irq,
  output logic [8:0]       pages_per_block,
  output logic [OFS_W+2:0] buf_addr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  input  logic [7:0]       buf_rdata,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic [NCS-1:0]   nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb_n
);
  logic fin, go, srst_on;
  op_e  op;
  logic [7:0] cmd_byte, adr_byte;
  logic [2:0] rba;
  logic [SPARE_W-1:0] spare_words;

  nand_eng_regs #(.SPARE_W(SPARE_W), .NCS(NCS), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fin(fin), .go(go), .op(op), .cmd_byte(cmd_byte),
    .adr_byte(adr_byte), .rba(rba), .spare_words(spare_words), .srst_on(srst_on),
    .irq(irq), .ce_n(nand_ce_n), .ppb(pages_per_block)
  );

  nand_eng_seq #(.PAGE_BYTES(PAGE_BYTES), .SPARE_W(SPARE_W), .OFS_W(OFS_W),
    .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI), .ID_BYTES(ID_BYTES)) u_seq (
    .clk(clk), .clr(rst || srst_on), .go(go), .op(op), .cmd_byte(cmd_byte),
    .adr_byte(adr_byte), .rba(rba), .spare_words(spare_words), .fin(fin),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .io_in(nand_io_in), .rb_n(nand_rb_n)
  );
endmodule

// File: tb/nand_op_engine_bench.sv
`timescale 1ns/1ps
module nand_op_engine_bench;
  localparam int PG = 128, SPW = 7, WL = 2, WH = 3, RL = 3, RH = 2, IDN = 5, RSTC = 4;
  localparam int OFS_W = $clog2(PG + 2 * ((1 << SPW) - 1));
  localparam int BAW = OFS_W + 3;
  localparam int DEPTH = 1 << OFS_W;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, buf_we, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [8:0] pages_per_block;
  logic [BAW-1:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata, nand_io_out, nand_io_in;
  logic [3:0] nand_ce_n;
  logic nand_rb_n = 1'b1;

  always #2.5 clk = ~clk;

  nand_op_engine #(.PAGE_BYTES(PG), .SPARE_W(SPW), .NCS(4), .WE_LO(WL), .WE_HI(WH),
    .RE_LO(RL), .RE_HI(RH), .ID_BYTES(IDN), .RST_CYC(RSTC)) u_nand_op_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .pages_per_block(pages_per_block),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n));

  int checks = 0, errors = 0;
  logic [7:0] mem [0:DEPTH-1];
  logic [7:0] src [0:DEPTH-1];
  logic [7:0] wlog [0:DEPTH-1];
  logic [OFS_W-1:0] rd_idx = '0;
  int wcnt = 0, wcle = 0, wale = 0, rcnt = 0, rfall = 0, wbad = 0, rbad = 0, bank_err = 0;
  logic [2:0] exp_bank = '0;
  realtime t_wf = 0, t_rf = 0;

  // buffer RAM model, one-clock read latency
  always @(posedge clk) begin
    if (buf_we) mem[buf_addr[OFS_W-1:0]] <= buf_wdata;
    buf_rdata <= mem[buf_addr[OFS_W-1:0]];
    if (buf_we && buf_addr[BAW-1:OFS_W] != exp_bank) bank_err++;
  end

  // flash model
  assign nand_io_in = src[rd_idx];
  always @(negedge nand_we_n) t_wf = $realtime;
  always @(posedge nand_we_n) begin
    if (wcnt < DEPTH) wlog[wcnt] = nand_io_out;
    if (nand_cle) wcle++;
    if (nand_ale) wale++;
    wcnt++;
    if ($realtime - t_wf != WL * 5.0) wbad++;
  end
  always @(negedge nand_re_n) begin rfall++; t_rf = $realtime; end
  always @(posedge nand_re_n) begin
    rd_idx++; rcnt++;
    if ($realtime - t_rf != RL * 5.0) rbad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic clr_log();
    wcnt = 0; wcle = 0; wale = 0; rcnt = 0; rfall = 0; rd_idx = '0;
  endtask

  task automatic wait_done(output bit ok);
    logic [15:0] v;
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd2, v);
      if (v[15]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 7 + salt) ^ (i >> 3));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bit ok;
    int sp, tot, bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; src[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    clr_log(); wbad = 0; rbad = 0; bank_err = 0;

    // reset state
    rd(3'd2, v); chk(v == 16'h0000, "R3 reset trigger", v, 0);
    chk(irq == 1'b0, "R4 reset irq", irq, 0);
    chk(nand_ce_n == 4'hF, "R12 reset ce_n", nand_ce_n, 15);
    chk(nand_we_n && nand_re_n, "R14 reset strobes", {nand_we_n, nand_re_n}, 3);

    // R1 command cycles
    for (int k = 0; k < 6; k++) begin
      logic [15:0] c = 16'($urandom);
      clr_log(); wr(3'd0, c); wr(3'd2, 16'h0001); wait_done(ok);
      chk(ok && wcnt == 1 && wlog[0] == c[7:0], "R1 cmd byte", wlog[0], c[7:0]);
      chk(wcle == 1 && wale == 0, "R1 cmd latch pins", wcle * 10 + wale, 10);
      wr(3'd2, 16'h0000);
    end
    // R2 address cycles
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a = 16'($urandom);
      clr_log(); wr(3'd1, a); wr(3'd2, 16'h0002); wait_done(ok);
      chk(ok && wcnt == 1 && wlog[0] == a[7:0], "R2 addr byte", wlog[0], a[7:0]);
      chk(wale == 1 && wcle == 0, "R2 addr latch pins", wale * 10 + wcle, 10);
      if (k < 5) wr(3'd2, 16'h0000);
    end

    // R3 sticky done
    wr(3'd2, 16'h8000); rd(3'd2, v);
    chk(v == 16'h8000, "R3 done kept by bit15 write", v, 16'h8000);
    wr(3'd2, 16'h0000); rd(3'd2, v);
    chk(v == 16'h0000, "R3 done cleared", v, 0);

    // R4 mask and unmask
    wr(3'd3, 16'h0010); wr(3'd0, 16'h0070); wr(3'd2, 16'h0001); wait_done(ok);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4 masked irq", irq, 0);
    wr(3'd3, 16'h0000); @(negedge clk);
    chk(irq == 1'b1, "R4 unmask raises irq", irq, 1);
    wr(3'd2, 16'h0000); @(negedge clk);
    chk(irq == 1'b0, "R4 irq follows done clear", irq, 0);

    // R6 priority: cmd+addr -> cmd only; id+status -> id only
    clr_log(); wr(3'd0, 16'h00A5); wr(3'd2, 16'h0003); wait_done(ok);
    chk(wcnt == 1 && wcle == 1 && wale == 0, "R6 lowest bit wins (cmd)", wcnt * 100 + wcle * 10 + wale, 110);
    wr(3'd2, 16'h0000);
    for (int i = 0; i < IDN; i++) src[i] = pat(i, 91);
    clr_log(); exp_bank = 3'd0; wr(3'd4, 16'h0005); wr(3'd2, 16'h0030); wait_done(ok);
    chk(rcnt == IDN, "R6 lowest bit wins (id)", rcnt, IDN);
    wr(3'd2, 16'h0000);

    // R7 page read behind busy, with R5 ignored trigger
    wr(3'd4, 16'h0000);
    sp = 1 + int'($urandom % 8); tot = PG + 2 * sp;
    wr(3'd5, 16'(sp));
    for (int i = 0; i < DEPTH; i++) begin src[i] = 8'($urandom); mem[i] = 8'h00; end
    nand_rb_n = 1'b0; clr_log();
    wr(3'd2, 16'h0008);
    repeat (40) @(negedge clk);
    chk(rfall == 0, "R7 no read strobe while busy", rfall, 0);
    wr(3'd2, 16'h0001); rd(3'd2, v);
    chk(v == 16'h0008, "R5 busy readback ignores trigger", v, 8);
    chk(wcnt == 0, "R5 ignored trigger no pulse", wcnt, 0);
    nand_rb_n = 1'b1; wait_done(ok);
    chk(ok && rcnt == tot, "R7 page read byte count", rcnt, tot);
    bad = 0;
    for (int i = 0; i < tot; i++) if (mem[i] != src[i]) bad++;
    chk(bad == 0, "R7 page read buffer image", bad, 0);
    chk(bank_err == 0, "R7 buffer number", bank_err, 0);
    wr(3'd2, 16'h0000);

    // R8 page program
    sp = 1 + int'($urandom % 8); tot = PG + 2 * sp;
    wr(3'd5, 16'(sp));
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
    clr_log(); wr(3'd2, 16'h0004); wait_done(ok);
    chk(ok && wcnt == tot, "R8 program byte count", wcnt, tot);
    bad = 0;
    for (int i = 0; i < tot; i++) if (wlog[i] != mem[i]) bad++;
    chk(bad == 0, "R8 program data", bad, 0);
    chk(wcle == 0 && wale == 0, "R8 latch pins low", wcle + wale, 0);
    wr(3'd2, 16'h0000);

    // R9 id read into buffer 0 despite buffer number 5
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hEE;
    for (int i = 0; i < 8; i++) src[i] = pat(i, 33);
    wr(3'd4, 16'h0005); clr_log(); bank_err = 0; exp_bank = 3'd0;
    wr(3'd2, 16'h0010); wait_done(ok);
    bad = 0;
    for (int i = 0; i < IDN; i++) if (mem[i] != pat(i, 33)) bad++;
    chk(ok && bad == 0 && rcnt == IDN, "R9 id bytes", rcnt, IDN);
    chk(mem[IDN] == 8'hEE && bank_err == 0, "R9 id bounds and buffer 0", mem[IDN], 8'hEE);
    wr(3'd2, 16'h0000);

    // R10 status read
    src[0] = 8'hC3;
    clr_log(); wr(3'd2, 16'h0020); wait_done(ok);
    chk(ok && rcnt == 1 && mem[0] == 8'hC3, "R10 status byte", mem[0], 8'hC3);
    chk(mem[1] == pat(1, 33), "R10 single byte only", mem[1], pat(1, 33));

    // R11 soft reset aborts a parked page read and clears done
    wr(3'd4, 16'h0000); nand_rb_n = 1'b0;
    wr(3'd2, 16'h8008);
    repeat (5) @(negedge clk);
    wr(3'd3, 16'h0040); rd(3'd3, v);
    chk(v[6] == 1'b1, "R11 reset bit reads 1", v[6], 1);
    repeat (RSTC + 4) @(negedge clk);
    rd(3'd3, v); chk(v[6] == 1'b0, "R11 reset bit self-clears", v[6], 0);
    rd(3'd2, v); chk(v == 16'h0000, "R11 op aborted", v, 0);
    nand_rb_n = 1'b1;
    clr_log(); wr(3'd0, 16'h0090); wr(3'd2, 16'h0001); wait_done(ok);
    chk(ok && wcnt == 1 && wlog[0] == 8'h90, "R11 engine usable after reset", wlog[0], 8'h90);
    wr(3'd2, 16'h0000);

    // R12 chip enables
    for (int cs = 0; cs < 4; cs++) begin
      wr(3'd4, 16'(cs << 5)); wr(3'd3, 16'h0080); @(negedge clk);
      chk(nand_ce_n == ~(4'b1 << cs), "R12 selected ce_n", nand_ce_n, ~(4'b1 << cs));
    end
    wr(3'd3, 16'h0000); @(negedge clk);
    chk(nand_ce_n == 4'hF, "R12 ce disabled", nand_ce_n, 15);

    // R13 pages per block
    for (int f = 0; f < 4; f++) begin
      wr(3'd3, 16'(f << 9)); @(negedge clk);
      chk(pages_per_block == 9'(32 << f), "R13 ppb decode", pages_per_block, 32 << f);
    end

    // R14 strobe widths across all runs
    chk(wbad == 0, "R14 write strobe width", wbad, 0);
    chk(rbad == 0, "R14 read strobe width", rbad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule